// File: doc/BRIEF.md
# Syndrome History Reconfiguration Controller

This controller sits beside the receive side of an error-detecting link whose 20-bit check syndrome is formed from four interleaved sections of 5 bits each. Each syndrome it accepts is written into a three-entry ring. In normal operation only failed transfers (nonzero syndromes) are written. While the link runs in its time-redundant split mode, every syndrome is written. The controller compares the three stored copies of each section's 5-bit segment. When one section shows the same nonzero value three times, the fault is treated as lasting rather than transient.

For a lasting fault, the segment value is turned into a wire location. A 7-bit steering vector carrying the section index and that location is then presented until the link side acknowledges it. Each section owns one spare wire, so it can be steered only once between resets. A segment value that does not identify a single wire never produces a vector. When several sections flag together, the lowest-numbered one is served first. The others wait and are served after the current vector is acknowledged.

Two summary outputs drive the split-mode variant. One is a fault indication raised while any section holds three equal nonzero values. The other is a clean indication raised while the whole history is zero, which allows a return to normal mode.

Top module: `syn_reconf_ctrl`

## Requirements
- R1: A synchronous active-low reset clears the history, the write position, every spare-used flag and any presented vector. After reset `vec_valid`=0, `perm_err`=0 and `hist_zero`=1.
- R2: A syndrome sampled with `syn_valid`=1 is written into the next ring slot (three slots, oldest overwritten). When `split_mode`=0, an all-zero syndrome is not written. When `split_mode`=1, every syndrome is written, including zero.
- R3: Section s owns bits `syn_in[5s+4:5s]`. A section is flagged when all three stored segments are equal and nonzero. `perm_err` is the OR of all section flags and follows the history one edge after the write.
- R4: `hist_zero` is 1 exactly when all three stored syndromes are zero.
- R5: A segment value v from 1 to 21 names wire location v. Values 0 and 22 to 31 name no wire. A section flagged with such a value produces no vector.
- R6: `vec_out` = {section index (bits 6:5), wire location (bits 4:0)}. `vec_valid` rises on the edge after a usable flag appears while no vector is presented. The vector then stays unchanged until `vec_ack` is sampled high, and `vec_valid` falls on that edge.
- R7: When several sections are usable at once, the lowest section index is presented first. Each remaining section is presented on the edge after the previous vector's acknowledge edge.
- R8: After a vector is issued for a section, no further vector is issued for that section until reset, even if it flags again.
- R9: Issuing a vector clears that section's segment in all three history entries. The other sections' segments are left untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| split_mode | input | 1 | Link is in time-redundant split mode; zero syndromes are recorded |
| syn_valid | input | 1 | A transfer's syndrome is present on `syn_in` |
| syn_in | input | 20 | Syndrome, four 5-bit section segments |
| vec_ack | input | 1 | The presented vector has been delivered |
| vec_valid | output | 1 | A steering vector is presented |
| vec_out | output | 7 | Section index (6:5) and wire location (4:0) |
| perm_err | output | 1 | Some section holds three equal nonzero segments |
| hist_zero | output | 1 | All stored syndromes are zero |

## Verification
The bench puts a zero syndrome between repeated failures in normal mode. A design that recorded it would never flag. It also sends zeros in split mode, where a design that dropped them would never report a clean history. Two sections flag on the same write to test arbitration. A wrong design would present the higher index first, or drop the losing section instead of serving it after the acknowledge. A section whose spare is already spent is made to fault again, and a segment value outside 1 to 21 is repeated. In each case a faulty design would issue a second or a meaningless vector. Random syndromes drawn from small per-section pools, with random acknowledge delays, are compared cycle by cycle against a model built from the requirements. This exposes stale history left behind after a clear and vectors that change before their acknowledge.

// File: rtl/rc_pkg.sv
`timescale 1ns/1ps
// Shared defaults for the syndrome history reconfiguration controller.
// Assumes a 4-section interleaved code with 5-bit per-section syndromes.
package rc_pkg;
    localparam int RC_NUM_SEC   = 4;   // interleaving sections
    localparam int RC_SEG_W     = 5;   // syndrome bits per section
    localparam int RC_DEPTH     = 3;   // history entries compared
    localparam int RC_NUM_WIRES = 21;  // wires per section (data + check)
endpackage

// File: rtl/rc_history.sv
`timescale 1ns/1ps
// Ring of DEPTH syndrome entries with per-section clearing.
// Assumes: a write and a clear in the same cycle are both applied, and the
// clear wins for the cleared section's segment in every entry.
module rc_history #(
    parameter int NUM_SEC = 4,
    parameter int SEG_W   = 5,
    parameter int DEPTH   = 3,
    localparam int SYN_W  = NUM_SEC * SEG_W,
    localparam int SEC_W  = (NUM_SEC > 1) ? $clog2(NUM_SEC) : 1,
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [SYN_W-1:0]       wr_data,
    input  logic                   clr_en,
    input  logic [SEC_W-1:0]       clr_sec,
    output logic [DEPTH*SYN_W-1:0] hist_flat
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [SYN_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wptr;

    // Purpose: record syndromes round-robin and wipe a steered section.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            for (int d = 0; d < DEPTH; d++) mem[d] <= '0;
        end else begin
            if (wr_en) begin
                mem[wptr] <= wr_data;
                wptr      <= (wptr == LAST) ? '0 : wptr + 1'b1;
            end
            if (clr_en) begin
                for (int d = 0; d < DEPTH; d++) begin
                    for (int s = 0; s < NUM_SEC; s++) begin
                        if (clr_sec == SEC_W'(s)) mem[d][s*SEG_W +: SEG_W] <= '0;
                    end
                end
            end
        end
    end

    // Purpose: expose the ring as one flat vector, entry d at slice d.
    generate
        for (genvar d = 0; d < DEPTH; d++) begin : g_flat
            assign hist_flat[d*SYN_W +: SYN_W] = mem[d];
        end
    endgenerate
endmodule

// File: rtl/rc_section_judge.sv
`timescale 1ns/1ps
// Judges one section: repeated nonzero fault, all-zero history, and the
// wire location its segment names. Assumes the single-error code maps
// syndrome value v (1..NUM_WIRES) to wire v; other values name no wire.
module rc_section_judge #(
    parameter int SEG_W     = 5,
    parameter int DEPTH     = 3,
    parameter int NUM_WIRES = 21
) (
    input  logic [DEPTH*SEG_W-1:0] segs,
    input  logic                   used,
    output logic                   flag,
    output logic                   zero,
    output logic                   cand,
    output logic [SEG_W-1:0]       loc
);
    localparam logic [SEG_W-1:0] MAXLOC = SEG_W'(NUM_WIRES);

    logic [SEG_W-1:0] head;
    logic             same;

    assign head = segs[0 +: SEG_W];

    // Purpose: compare every stored copy against the newest-independent head.
    always_comb begin
        same = 1'b1;
        zero = 1'b1;
        for (int d = 0; d < DEPTH; d++) begin
            if (segs[d*SEG_W +: SEG_W] != head) same = 1'b0;
            if (segs[d*SEG_W +: SEG_W] != '0)   zero = 1'b0;
        end
    end

    // Purpose: decode location and decide whether this section may be steered.
    always_comb begin
        flag = same && (head != '0);
        loc  = ((head != '0) && (head <= MAXLOC)) ? head : '0;
        cand = flag && !used && (loc != '0);
    end
endmodule

// File: rtl/rc_prio_arb.sv
`timescale 1ns/1ps
// Fixed-priority pick: lowest requesting index wins.
// Assumes requests are held by their owners until served.
module rc_prio_arb #(
    parameter int N     = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // Purpose: scan from the top so the lowest set index is left in idx.
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/syn_reconf_ctrl.sv
`timescale 1ns/1ps
// Syndrome history reconfiguration controller (top).
// Records syndromes, detects lasting per-section faults, and presents one
// steering vector at a time, spending each section's spare at most once.
// Assumes vec_ack is only meaningful while vec_valid is high.
module syn_reconf_ctrl
    import rc_pkg::*;
#(
    parameter int NUM_SEC   = RC_NUM_SEC,
    parameter int SEG_W     = RC_SEG_W,
    parameter int DEPTH     = RC_DEPTH,
    parameter int NUM_WIRES = RC_NUM_WIRES,
    localparam int SYN_W    = NUM_SEC * SEG_W,
    localparam int SEC_W    = (NUM_SEC > 1) ? $clog2(NUM_SEC) : 1,
    localparam int VEC_W    = SEC_W + SEG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             split_mode,
    input  logic             syn_valid,
    input  logic [SYN_W-1:0] syn_in,
    input  logic             vec_ack,
    output logic             vec_valid,
    output logic [VEC_W-1:0] vec_out,
    output logic             perm_err,
    output logic             hist_zero
);
    logic                   wr_en;
    logic [DEPTH*SYN_W-1:0] hist_flat;
    logic [NUM_SEC-1:0]     sec_flag;
    logic [NUM_SEC-1:0]     sec_zero;
    logic [NUM_SEC-1:0]     sec_cand;
    logic [NUM_SEC-1:0]     spare_used;
    logic [SEG_W-1:0]       sec_loc [NUM_SEC];
    logic                   cand_any;
    logic [SEC_W-1:0]       win_idx;
    logic                   issue;
    logic                   vec_valid_q;
    logic [VEC_W-1:0]       vec_q;

    // Purpose: zero syndromes are history only while in split mode.
    assign wr_en = syn_valid && (split_mode || (syn_in != '0));

    rc_history #(
        .NUM_SEC (NUM_SEC),
        .SEG_W   (SEG_W),
        .DEPTH   (DEPTH)
    ) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (syn_in),
        .clr_en    (issue),
        .clr_sec   (win_idx),
        .hist_flat (hist_flat)
    );

    // Purpose: one judge per section over its segment in every entry.
    generate
        for (genvar s = 0; s < NUM_SEC; s++) begin : g_sec
            logic [DEPTH*SEG_W-1:0] segs;
            for (genvar d = 0; d < DEPTH; d++) begin : g_seg
                assign segs[d*SEG_W +: SEG_W] = hist_flat[d*SYN_W + s*SEG_W +: SEG_W];
            end
            rc_section_judge #(
                .SEG_W     (SEG_W),
                .DEPTH     (DEPTH),
                .NUM_WIRES (NUM_WIRES)
            ) u_judge (
                .segs (segs),
                .used (spare_used[s]),
                .flag (sec_flag[s]),
                .zero (sec_zero[s]),
                .cand (sec_cand[s]),
                .loc  (sec_loc[s])
            );
        end
    endgenerate

    rc_prio_arb #(
        .N (NUM_SEC)
    ) u_arb (
        .req (sec_cand),
        .any (cand_any),
        .idx (win_idx)
    );

    // Purpose: start a new vector only when none is outstanding.
    assign issue = !vec_valid_q && cand_any;

    // Purpose: hold the presented vector and the per-section spare flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_valid_q <= 1'b0;
            vec_q       <= '0;
            spare_used  <= '0;
        end else if (issue) begin
            vec_valid_q         <= 1'b1;
            vec_q               <= {win_idx, sec_loc[win_idx]};
            spare_used[win_idx] <= 1'b1;
        end else if (vec_valid_q && vec_ack) begin
            vec_valid_q <= 1'b0;
        end
    end

    assign vec_valid = vec_valid_q;
    assign vec_out   = vec_q;
    assign perm_err  = |sec_flag;
    assign hist_zero = &sec_zero;
endmodule

// File: rtl/rc_checker.sv
`timescale 1ns/1ps
// Property checker for syn_reconf_ctrl, attached by bind below.
module rc_checker #(
    parameter int NUM_SEC   = 4,
    parameter int SEG_W     = 5,
    parameter int NUM_WIRES = 21,
    localparam int SEC_W    = (NUM_SEC > 1) ? $clog2(NUM_SEC) : 1,
    localparam int VEC_W    = SEC_W + SEG_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               vec_valid,
    input logic [VEC_W-1:0]   vec_out,
    input logic               vec_ack,
    input logic               perm_err,
    input logic               hist_zero,
    input logic [NUM_SEC-1:0] spare_used
);
    localparam logic [SEG_W-1:0] MAXLOC = SEG_W'(NUM_WIRES);

    AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && !vec_ack) |=> (vec_valid && $stable(vec_out))); // R6

    AST_VEC_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && vec_ack) |=> !vec_valid); // R6

    AST_LOC_NAMES_WIRE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> ((vec_out[SEG_W-1:0] != '0) && (vec_out[SEG_W-1:0] <= MAXLOC))); // R5

    AST_SPARE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(spare_used) & ~spare_used) == '0)); // R8

    AST_SPARE_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_valid) |-> (($past(spare_used) & (NUM_SEC'(1) << vec_out[VEC_W-1 -: SEC_W])) == '0)); // R8

    AST_CLEAN_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        hist_zero |-> !perm_err); // R4
endmodule

bind syn_reconf_ctrl rc_checker #(
    .NUM_SEC   (NUM_SEC),
    .SEG_W     (SEG_W),
    .NUM_WIRES (NUM_WIRES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .vec_valid  (vec_valid),
    .vec_out    (vec_out),
    .vec_ack    (vec_ack),
    .perm_err   (perm_err),
    .hist_zero  (hist_zero),
    .spare_used (spare_used)
);

// File: tb/sim_syn_reconf_ctrl.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random traffic, checked against
// a cycle model written from the requirements.
module sim_syn_reconf_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        split_mode = 1'b0;
    logic        syn_valid = 1'b0;
    logic [19:0] syn_in = '0;
    logic        vec_ack = 1'b0;
    logic        vec_valid;
    logic [6:0]  vec_out;
    logic        perm_err;
    logic        hist_zero;

    int checks = 0;
    int fails  = 0;
    bit cmp_en = 1'b0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    syn_reconf_ctrl u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .split_mode (split_mode),
        .syn_valid  (syn_valid),
        .syn_in     (syn_in),
        .vec_ack    (vec_ack),
        .vec_valid  (vec_valid),
        .vec_out    (vec_out),
        .perm_err   (perm_err),
        .hist_zero  (hist_zero)
    );

    // ---------------- reference model ----------------
    logic [19:0] m_hist [3];
    int          m_wptr;
    bit   [3:0]  m_used;
    bit          m_vv;
    bit   [6:0]  m_vec;

    function automatic logic [4:0] m_seg(int d, int s);
        return m_hist[d][s*5 +: 5];
    endfunction

    function automatic bit m_flag(int s);
        logic [4:0] v;
        v = m_seg(0, s);
        return (v != 0) && (m_seg(1, s) == v) && (m_seg(2, s) == v);
    endfunction

    function automatic logic [4:0] m_loc(int s);
        logic [4:0] v;
        v = m_seg(0, s);
        return (v >= 1 && v <= 21) ? v : 5'd0;
    endfunction

    function automatic bit m_any_flag();
        for (int s = 0; s < 4; s++) if (m_flag(s)) return 1'b1;
        return 1'b0;
    endfunction

    function automatic bit m_all_zero();
        return (m_hist[0] == 0) && (m_hist[1] == 0) && (m_hist[2] == 0);
    endfunction

    always @(posedge clk) begin
        int         pick;
        logic [4:0] ploc;
        pick = -1;
        ploc = '0;
        if (!rst_n) begin
            for (int d = 0; d < 3; d++) m_hist[d] = '0;
            m_wptr = 0;
            m_used = '0;
            m_vv   = 1'b0;
            m_vec  = '0;
        end else begin
            if (!m_vv) begin
                for (int s = 0; s < 4; s++)
                    if (pick < 0 && m_flag(s) && !m_used[s] && m_loc(s) != 0) pick = s;
            end
            if (pick >= 0) ploc = m_loc(pick);
            if (syn_valid && (split_mode || syn_in != 0)) begin
                m_hist[m_wptr] = syn_in;
                m_wptr = (m_wptr + 1) % 3;
            end
            if (pick >= 0) begin
                m_vv = 1'b1;
                m_vec = {2'(pick), ploc};
                m_used[pick] = 1'b1;
                for (int d = 0; d < 3; d++) m_hist[d][pick*5 +: 5] = '0;
            end else if (m_vv && vec_ack) begin
                m_vv = 1'b0;
            end
        end
    end

    // ---------------- checking ----------------
    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en) begin
            chk("R6", "model vec_valid", int'(vec_valid), int'(m_vv));
            if (m_vv) chk("R6", "model vec_out", int'(vec_out), int'(m_vec));
            chk("R3", "model perm_err", int'(perm_err), int'(m_any_flag()));
            chk("R4", "model hist_zero", int'(hist_zero), int'(m_all_zero()));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; syn_valid = 1'b0; vec_ack = 1'b0; split_mode = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send(logic [19:0] v, bit split);
        syn_valid = 1'b1; syn_in = v; split_mode = split;
        @(negedge clk);
        syn_valid = 1'b0; syn_in = '0;
    endtask

    task automatic ack_once();
        vec_ack = 1'b1;
        @(negedge clk);
        vec_ack = 1'b0;
    endtask

    initial begin
        logic [4:0] pool [4][2];
        void'($urandom(32'd2024));

        // R1: reset state
        do_reset();
        cmp_en = 1'b1;
        chk("R1", "vec_valid after reset", int'(vec_valid), 0);
        chk("R1", "perm_err after reset", int'(perm_err), 0);
        chk("R1", "hist_zero after reset", int'(hist_zero), 1);

        // R2/R3: zero syndrome between failures is not recorded in normal mode
        @(negedge clk);
        send(20'h00005, 1'b0);
        send(20'h00000, 1'b0);
        send(20'h00005, 1'b0);
        chk("R3", "two copies only", int'(perm_err), 0);
        send(20'h00005, 1'b0);
        chk("R2", "third copy flags (zero skipped)", int'(perm_err), 1);
        chk("R6", "no vector yet", int'(vec_valid), 0);
        @(negedge clk);
        chk("R6", "vector presented", int'(vec_valid), 1);
        chk("R6", "vector sec0 loc5", int'(vec_out), 'h05);
        chk("R9", "section cleared", int'(perm_err), 0);
        chk("R9", "history clean", int'(hist_zero), 1);
        repeat (3) @(negedge clk);
        chk("R6", "held without ack", int'(vec_out), 'h05);
        chk("R6", "still valid", int'(vec_valid), 1);
        ack_once();
        chk("R6", "dropped after ack", int'(vec_valid), 0);

        // R8: spent section flags again but gets no vector
        send(20'h00005, 1'b0);
        send(20'h00005, 1'b0);
        send(20'h00005, 1'b0);
        chk("R8", "reflagged", int'(perm_err), 1);
        repeat (3) @(negedge clk);
        chk("R8", "no second vector", int'(vec_valid), 0);

        // R7/R9: two sections at once, lowest first, second after ack
        do_reset();
        for (int i = 0; i < 3; i++) send((20'd9 << 10) | (20'd7 << 5), 1'b0);
        chk("R3", "both flagged", int'(perm_err), 1);
        @(negedge clk);
        chk("R7", "lower section first", int'(vec_out), 'h27);
        chk("R9", "other section kept", int'(perm_err), 1);
        @(negedge clk);
        ack_once();
        chk("R7", "gap after ack", int'(vec_valid), 0);
        @(negedge clk);
        chk("R7", "second section next", int'(vec_valid), 1);
        chk("R7", "vector sec2 loc9", int'(vec_out), 'h49);
        chk("R9", "all flags cleared", int'(perm_err), 0);
        ack_once();

        // R5: segment values naming no wire
        do_reset();
        for (int i = 0; i < 3; i++) send((20'd25 << 15) | 20'd22, 1'b0);
        chk("R5", "flag on non-wire value", int'(perm_err), 1);
        repeat (3) @(negedge clk);
        chk("R5", "no vector for non-wire", int'(vec_valid), 0);

        // R2/R4: zero recording depends on split mode
        do_reset();
        send(20'h00003 << 10, 1'b0);
        chk("R4", "history dirty", int'(hist_zero), 0);
        for (int i = 0; i < 3; i++) send(20'h0, 1'b0);
        chk("R2", "normal mode zeros ignored", int'(hist_zero), 0);
        for (int i = 0; i < 3; i++) send(20'h0, 1'b1);
        chk("R2", "split mode zeros recorded", int'(hist_zero), 1);

        // Random rounds
        for (int r = 0; r < 8; r++) begin
            do_reset();
            for (int s = 0; s < 4; s++) begin
                pool[s][0] = 5'($urandom % 32);
                pool[s][1] = 5'(1 + $urandom % 21);
            end
            for (int c = 0; c < 500; c++) begin
                logic [19:0] v;
                for (int s = 0; s < 4; s++)
                    v[s*5 +: 5] = ($urandom % 4 == 0) ? 5'd0 : pool[s][$urandom % 2];
                syn_valid  = ($urandom % 3 != 0);
                syn_in     = v;
                split_mode = r[0];
                vec_ack    = vec_valid && ($urandom % 4 == 0);
                @(negedge clk);
            end
            syn_valid = 1'b0;
            vec_ack = 1'b0;
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule